// File: doc/BRIEF.md
# Oversampled Audio Decimator

This block turns a pair of single-bit oversampled streams (left and right) into parallel PCM samples at the base audio rate. Every pulse of the clock enable `ce_128` delivers one new bit per channel, and 128 pulses make one output frame. Each input bit is read as +1 or −1. A third-order comb-integrator stage first reduces the rate by 16. Three half-band FIR stages then each halve the rate. A fixed output gain of 7/8 (about −1.16 dB) sets a full-scale input to a little under the peak code.

The half-band stages have symmetric kernels. The centre coefficient is one half, every second off-centre coefficient is zero, and the taps sum to unity. Each kernel is 7 or 11 taps long, chosen per stage by parameter. A stage computes only the outputs it keeps: one for every two inputs. After reset no strobe is given until every delay line holds data from the new stream, so the first sample delivered is already a settled value.

Top module: `audio_decimator`

## Requirements
- R1: An input bit of 1 counts as +1 and a 0 as −1. A constant 1 stream settles at +3584 on the 16-bit output, and a constant 0 stream settles at −3584.
- R2: The first stage is a third-order comb-integrator that decimates by 16 with a DC gain of 4096. Any input pattern that repeats every 16 enable pulses and has P ones per period gives a constant output of 224·(2P−16) on every strobe.
- R3: `pcm_valid` is high for exactly one clock, and consecutive strobes are exactly 128 enable pulses apart.
- R4: With the default stage lengths (7, 7 and 11 taps), the first strobe after reset comes with the 1088th enable pulse. That is the point at which the first stage has produced three outputs and each half-band window has filled and reached an output phase.
- R5: Each half-band stage has unity DC gain with no rounding error, so the first strobe after reset already carries the exact steady-state value.
- R6: The output gain is 7/8, applied by multiplying and then shifting right arithmetically by 3 (floor).
- R7: The left and right channels are computed independently and strobe on the same clock.
- R8: While `ce_128` is low, no state advances and no strobe appears. When the enable resumes, the stream carries on with correct values and the frame spacing is unchanged.
- R9: An active-low asynchronous reset sets both outputs to zero, drops `pcm_valid` and restarts the fill count of R4.
- R10: `pcm_l` and `pcm_r` change only on a clock where `pcm_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_128 | input | 1 | One pulse per oversampled input bit (128 per output sample) |
| bit_l | input | 1 | Left modulator bit, sampled when `ce_128` is high |
| bit_r | input | 1 | Right modulator bit, sampled when `ce_128` is high |
| pcm_l | output | OUT_W (16) | Left PCM sample, two's complement |
| pcm_r | output | OUT_W (16) | Right PCM sample, two's complement |
| pcm_valid | output | 1 | One-clock strobe marking a new sample pair |

## Verification
The decimator is driven with 16-bit repeating bit patterns of different densities: all ones, all zeros, half density in both clustered and alternating forms, and sparse and dense patterns. Every such pattern lies in the null set of the comb stage apart from its mean, so the mean alone sets the exact output, 224·(2P−16). A wrong integrator chain, a wrong comb delay, a wrong half-band coefficient or a wrong gain therefore shows up as a wrong value rather than as a small error. Different patterns on the two channels expose any crossing between them. Counting enable pulses to the first strobe and between strobes separates the fill logic and the decimation phase from the arithmetic. An enable stall and a reset in the middle of the stream show that the state freezes and that it restarts.

// File: rtl/dec_pkg.sv
package dec_pkg;

   // Fraction bits of the integer half-band kernels.
   function automatic int hb_frac_bits(input int ntap);
      return (ntap == 11) ? 9 : 5;
   endfunction

   // Half-band coefficient k of an ntap kernel, scaled by 2**hb_frac_bits.
   // Centre is one half, even non-zero offsets are zero, taps sum to one.
   function automatic int hb_coef(input int ntap, input int k);
      int d;
      d = k - (ntap - 1) / 2;
      if (d < 0) d = -d;
      if (ntap == 11) begin
         case (d)
            0: return 256;
            1: return 150;
            3: return -25;
            5: return 3;
            default: return 0;
         endcase
      end
      case (d)
         0: return 16;
         1: return 9;
         3: return -1;
         default: return 0;
      endcase
   endfunction

   // Register width of a comb-integrator stage fed by a +/-1 input.
   function automatic int cic_width(input int order, input int ratio);
      return 2 + order * $clog2(ratio);
   endfunction

endpackage

// File: rtl/cic_decim.sv
module cic_decim #(
   parameter int ORDER = 3,
   parameter int RATIO = 16,
   parameter int W     = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce,
   input  logic                bit_in,
   output logic signed [W-1:0] dout,
   output logic                dout_vld
);
   localparam int PW = $clog2(RATIO);
   localparam int FW = $clog2(ORDER + 1);

   if ((1 << PW) != RATIO || RATIO < 2) begin : g_bad_ratio
      $error("cic_decim: RATIO must be a power of two of at least 2");
   end
   if (W < dec_pkg::cic_width(ORDER, RATIO)) begin : g_bad_width
      $error("cic_decim: W too small for the register growth");
   end
   if (ORDER < 1) begin : g_bad_order
      $error("cic_decim: ORDER must be at least 1");
   end

   logic signed [W-1:0] step;
   logic signed [W-1:0] acc_q  [ORDER];
   logic signed [W-1:0] acc_d  [ORDER];
   logic signed [W-1:0] dly_q  [ORDER];
   logic signed [W-1:0] diff   [ORDER+1];
   logic [PW-1:0]       ph_q;
   logic                stb_q;
   logic [FW-1:0]       fill_q;

   // bit 1 -> +1, bit 0 -> -1
   assign step = bit_in ? W'(1) : {W{1'b1}};

   // integrator chain, wrap-around arithmetic
   always_comb begin
      acc_d[0] = acc_q[0] + step;
      for (int i = 1; i < ORDER; i++) begin
         acc_d[i] = acc_q[i] + acc_d[i-1];
      end
   end

   // comb chain at the decimated rate
   always_comb begin
      diff[0] = acc_q[ORDER-1];
      for (int i = 0; i < ORDER; i++) begin
         diff[i+1] = diff[i] - dly_q[i];
      end
   end

   for (genvar g = 0; g < ORDER; g++) begin : g_stage
      logic signed [W-1:0] acc_r;
      logic signed [W-1:0] dly_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_r <= '0;
            dly_r <= '0;
         end else begin
            if (ce)    acc_r <= acc_d[g];
            if (stb_q) dly_r <= diff[g];
         end
      end
      assign acc_q[g] = acc_r;
      assign dly_q[g] = dly_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         stb_q <= 1'b0;
      end else begin
         stb_q <= ce && (ph_q == PW'(RATIO - 1));
         if (ce) ph_q <= ph_q + 1'b1;
      end
   end

   // first ORDER-1 outputs still see pre-reset history: withhold them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout     <= '0;
         dout_vld <= 1'b0;
         fill_q   <= '0;
      end else begin
         dout_vld <= 1'b0;
         if (stb_q) begin
            dout <= diff[ORDER];
            if (fill_q == FW'(ORDER - 1)) dout_vld <= 1'b1;
            else                          fill_q   <= fill_q + 1'b1;
         end
      end
   end

   p_stb_needs_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stb_q |-> $past(ce));
   p_out_needs_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |-> $past(stb_q));
   p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      stb_q |=> !stb_q);

endmodule

// File: rtl/hb_decim.sv
module hb_decim #(
   parameter int NTAP = 7,
   parameter int W    = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic signed [W-1:0] din,
   input  logic                din_vld,
   output logic signed [W-1:0] dout,
   output logic                dout_vld
);
   localparam int FB = dec_pkg::hb_frac_bits(NTAP);
   localparam int AW = W + FB + 4;
   localparam int CW = $clog2(NTAP + 1);
   localparam logic signed [AW-1:0] HI = AW'((2 ** (W - 1)) - 1);
   localparam logic signed [AW-1:0] LO = -HI - AW'(1);

   if (NTAP != 7 && NTAP != 11) begin : g_bad_len
      $error("hb_decim: NTAP must be 7 or 11");
   end

   logic signed [W-1:0]  tap_q [NTAP];
   logic signed [AW-1:0] prod  [NTAP];
   logic signed [AW-1:0] acc;
   logic signed [AW-1:0] scl;
   logic signed [W-1:0]  sat;
   logic [CW-1:0]        cnt_q;
   logic                 ph_q;
   logic                 go_q;

   for (genvar k = 0; k < NTAP; k++) begin : g_tap
      localparam int C = dec_pkg::hb_coef(NTAP, k);
      logic signed [W-1:0] t_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       t_r <= '0;
         else if (din_vld) t_r <= (k == 0) ? din : tap_q[(k == 0) ? 0 : k - 1];
      end
      assign tap_q[k] = t_r;
      if (C != 0) begin : g_mul
         assign prod[k] = AW'(t_r) * AW'(C);
      end else begin : g_zero
         assign prod[k] = '0;
      end
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < NTAP; k++) acc = acc + prod[k];
   end

   assign scl = acc >>> FB;
   assign sat = (scl > HI) ? HI[W-1:0] : (scl < LO) ? LO[W-1:0] : scl[W-1:0];

   // keep outputs on the 2nd, 4th, ... input once the window is full
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ph_q  <= 1'b0;
         go_q  <= 1'b0;
      end else begin
         go_q <= 1'b0;
         if (din_vld) begin
            ph_q <= ~ph_q;
            if (cnt_q != CW'(NTAP)) cnt_q <= cnt_q + 1'b1;
            go_q <= ph_q && (cnt_q >= CW'(NTAP - 1));
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout     <= '0;
         dout_vld <= 1'b0;
      end else begin
         dout_vld <= go_q;
         if (go_q) dout <= sat;
      end
   end

   p_out_after_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |-> (cnt_q == CW'(NTAP)));
   p_out_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |=> !dout_vld);

endmodule

// File: rtl/audio_decimator.sv
module audio_decimator #(
   parameter int CIC_ORDER  = 3,
   parameter int CIC_RATIO  = 16,
   parameter int HB_TAPS_A  = 7,
   parameter int HB_TAPS_B  = 7,
   parameter int HB_TAPS_C  = 11,
   parameter int OUT_W      = 16,
   parameter int GAIN_NUM   = 7,
   parameter int GAIN_SHIFT = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ce_128,
   input  logic                    bit_l,
   input  logic                    bit_r,
   output logic signed [OUT_W-1:0] pcm_l,
   output logic signed [OUT_W-1:0] pcm_r,
   output logic                    pcm_valid
);
   localparam int W   = dec_pkg::cic_width(CIC_ORDER, CIC_RATIO);
   localparam int NHB = 3;
   localparam int GW  = W + $clog2(GAIN_NUM + 1) + 1;
   localparam int HBT [NHB] = '{HB_TAPS_A, HB_TAPS_B, HB_TAPS_C};

   if (OUT_W < W) begin : g_bad_out
      $error("audio_decimator: OUT_W narrower than the filter path");
   end
   if (GAIN_NUM < 1 || GAIN_NUM >= (1 << (GAIN_SHIFT + 1))) begin : g_bad_gain
      $error("audio_decimator: GAIN_NUM out of range for GAIN_SHIFT");
   end

   logic                    in_bit [2];
   logic signed [W-1:0]     sd     [2][NHB+1];
   logic                    sv     [2][NHB+1];
   logic signed [OUT_W-1:0] pcm    [2];
   logic                    pv     [2];

   assign in_bit[0] = bit_l;
   assign in_bit[1] = bit_r;

   for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      cic_decim #(.ORDER(CIC_ORDER), .RATIO(CIC_RATIO), .W(W)) u_cic (
         .clk      (clk),
         .rst_n    (rst_n),
         .ce       (ce_128),
         .bit_in   (in_bit[ch]),
         .dout     (sd[ch][0]),
         .dout_vld (sv[ch][0])
      );

      for (genvar s = 0; s < NHB; s++) begin : g_hb
         hb_decim #(.NTAP(HBT[s]), .W(W)) u_hb (
            .clk      (clk),
            .rst_n    (rst_n),
            .din      (sd[ch][s]),
            .din_vld  (sv[ch][s]),
            .dout     (sd[ch][s+1]),
            .dout_vld (sv[ch][s+1])
         );
      end

      logic signed [GW-1:0]    scaled;
      logic signed [OUT_W-1:0] q_r;
      logic                    v_r;

      assign scaled = (GW'(sd[ch][NHB]) * GW'(GAIN_NUM)) >>> GAIN_SHIFT;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_r <= '0;
            v_r <= 1'b0;
         end else begin
            v_r <= sv[ch][NHB];
            if (sv[ch][NHB]) q_r <= OUT_W'(scaled);
         end
      end

      assign pcm[ch] = q_r;
      assign pv[ch]  = v_r;
   end

   assign pcm_l     = pcm[0];
   assign pcm_r     = pcm[1];
   assign pcm_valid = pv[0];

   p_lockstep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pv[0] == pv[1]);
   p_strobe_one_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_valid |=> !pcm_valid);
   p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pcm_valid |-> ($stable(pcm_l) && $stable(pcm_r)));

endmodule

// File: tb/sim_audio_decimator.sv
module sim_audio_decimator;
   localparam int OUT_W    = 16;
   localparam int FILL_CE  = 1088;
   localparam int FRAME_CE = 128;
   localparam int NVEC     = 6;
   // {left pattern, right pattern}; bit i is used on enable pulse i mod 16
   localparam logic [31:0] VECS [NVEC] = '{
      32'hFFFF_0000, 32'hAAAA_7777, 32'h1111_5555,
      32'h7F7F_0101, 32'h00FF_FFFE, 32'h8001_FFFF
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_128 = 1'b0;
   logic bit_l = 1'b0;
   logic bit_r = 1'b0;
   logic signed [OUT_W-1:0] pcm_l;
   logic signed [OUT_W-1:0] pcm_r;
   logic pcm_valid;

   int n_chk = 0;
   int n_bad = 0;
   bit ce_on = 1'b0;
   int ce_per = 4;
   logic [15:0] pat_l = '0;
   logic [15:0] pat_r = '0;
   int idx = 0;
   int div = 0;
   int ce_cnt = 0;

   always #10 clk = ~clk;

   audio_decimator u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .ce_128    (ce_128),
      .bit_l     (bit_l),
      .bit_r     (bit_r),
      .pcm_l     (pcm_l),
      .pcm_r     (pcm_r),
      .pcm_valid (pcm_valid)
   );

   // enable and bit generator, driven on the falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         ce_128 = 1'b0;
         idx = 0;
         div = 0;
         ce_cnt = 0;
      end else if (!ce_on) begin
         ce_128 = 1'b0;
      end else begin
         if (div == 0) begin
            ce_128 = 1'b1;
            bit_l = pat_l[idx];
            bit_r = pat_r[idx];
            idx = (idx + 1) % 16;
            ce_cnt++;
         end else begin
            ce_128 = 1'b0;
         end
         div = (div + 1) % ce_per;
      end
   end

   // R2: steady output = 4096 * mean * 7/8 = 224 * (2P - 16)
   function automatic int dc_exp(input logic [15:0] p);
      return 224 * (2 * $countones(p) - 16);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_strobe();
      do @(negedge clk); while (!pcm_valid);
   endtask

   task automatic do_reset();
      ce_on = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R3 watchdog: got no completion expected a finished run");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int first;
      int prev;
      int seen;
      logic signed [OUT_W-1:0] l0;
      logic signed [OUT_W-1:0] r0;

      // reset state (R9)
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(pcm_valid == 1'b0, "R9", int'(pcm_valid), 0);
      chk(pcm_l == 0, "R9", pcm_l, 0);
      chk(pcm_r == 0, "R9", pcm_r, 0);
      rst_n = 1'b1;

      // vector table: each pattern from reset, three strobes checked
      for (int v = 0; v < NVEC; v++) begin
         do_reset();
         pat_l = VECS[v][31:16];
         pat_r = VECS[v][15:0];
         ce_per = 4;
         ce_on = 1'b1;
         for (int k = 0; k < 3; k++) begin
            wait_strobe();
            chk(pcm_l == dc_exp(pat_l), (k == 0) ? "R5" : "R2", pcm_l, dc_exp(pat_l));
            chk(pcm_r == dc_exp(pat_r), "R7", pcm_r, dc_exp(pat_r));
         end
         ce_on = 1'b0;
      end

      // fill latency, constants, gain, strobe shape and spacing
      do_reset();
      pat_l = 16'hFFFF;
      pat_r = 16'h0000;
      ce_per = 16;
      ce_on = 1'b1;
      wait_strobe();
      first = ce_cnt;
      chk(ce_cnt == FILL_CE, "R4", ce_cnt, FILL_CE);
      chk(pcm_l == 3584, "R1", pcm_l, 3584);
      chk(pcm_r == -3584, "R6", pcm_r, -3584);
      @(negedge clk);
      chk(pcm_valid == 1'b0, "R3", int'(pcm_valid), 0);
      l0 = pcm_l;
      r0 = pcm_r;
      repeat (20) @(negedge clk);
      chk(pcm_l == l0 && pcm_r == r0 && !pcm_valid, "R10", pcm_l, l0);
      wait_strobe();
      chk(ce_cnt - first == FRAME_CE, "R3", ce_cnt - first, FRAME_CE);
      prev = ce_cnt;

      // enable stall
      ce_on = 1'b0;
      l0 = pcm_l;
      seen = 0;
      repeat (3000) begin
         @(negedge clk);
         if (pcm_valid) seen++;
      end
      chk(seen == 0, "R8", seen, 0);
      chk(pcm_l == l0, "R8", pcm_l, l0);
      ce_on = 1'b1;
      wait_strobe();
      chk(ce_cnt - prev == FRAME_CE, "R8", ce_cnt - prev, FRAME_CE);
      chk(pcm_l == 3584, "R8", pcm_l, 3584);

      // reset in mid-stream, new patterns
      rst_n = 1'b0;
      @(negedge clk);
      chk(pcm_l == 0 && pcm_r == 0, "R9", pcm_l, 0);
      chk(pcm_valid == 1'b0, "R9", int'(pcm_valid), 0);
      @(negedge clk);
      pat_l = 16'h0000;
      pat_r = 16'hFFFF;
      rst_n = 1'b1;
      wait_strobe();
      chk(ce_cnt == FILL_CE, "R9", ce_cnt, FILL_CE);
      chk(pcm_l == -3584, "R1", pcm_l, -3584);
      chk(pcm_r == 3584, "R7", pcm_r, 3584);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule